// File: doc/BRIEF.md
# Gated Input Edge Counter

This block measures the frequency of an external square wave by counting its rising edges over a gate window of a programmed number of system-clock ticks. The input is not related to the system clock. It first passes through a synchronizer and then an edge detector. A self-reloading down-counter times the gate. Each time the gate expires, the number of edges seen in the window goes to an output register, and a one-cycle strobe marks the new value. The next window begins on that same cycle, so the windows follow one another with no gap.

The gate setting is the clock frequency multiplied by the gate time. With an 80 MHz clock and a setting of 80,000,000, each result is the input frequency in hertz, and one result arrives per second. A setting of 8,000,000 gives ten results per second, each counting edges over 0.1 s. The intended input range is about 3 kHz to 100 kHz. Converting a count to a period and averaging successive results are left to the consumer.

Top module: `freq_gate_counter`

## Requirements
- R1: The input passes through two synchronizing flops. A rising edge is the synchronized signal going from low in one cycle to high in the next. A transition from 0 to 1 that is first sampled at clock edge k is counted by the tally update at clock edge k+2.
- R2: Only rising edges are counted. A level held high, a level held low, and falling transitions add nothing to the count.
- R3: With a gate setting N >= 1, consecutive result strobes are exactly N clock cycles apart while the setting is unchanged.
- R4: At each result strobe, the result equals the number of rising edges whose tally update fell within the N cycles of the window just closed.
- R5: An edge whose tally update falls on the closing cycle of a window is counted in the next window. The new window's tally therefore starts at 1 on that cycle, or at 0 without an edge, and no edge is lost or counted twice.
- R6: A new gate setting takes effect only when the gate next reloads. The window already running keeps the length it was loaded with.
- R7: A gate setting of 0 is treated as 1.
- R8: Reset clears the result, the strobe and both counters. The first cycle after reset loads the gate and opens the first window, and no strobe is produced for it.
- R9: The result register holds its value between strobes, and the strobe lasts one cycle per window.
- R10: With a gate setting of 1, a result is produced on every cycle, each holding the edge count of a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_i | input | 1 | Square wave to be measured, asynchronous to clk |
| gate_ticks_i | input | TICK_W (27) | Gate length in clock cycles, used at each reload |
| count_o | output | CNT_W (27) | Edge count of the last completed window |
| count_valid_o | output | 1 | One-cycle strobe when count_o is updated |

## Verification
The bench builds the block with its default parameter values: 27-bit gate and count widths and a two-stage synchronizer. It programs small gate settings (0, 1, 2 and a few tens of ticks) so that hundreds of windows close within a few thousand cycles. These short windows place edges on window boundaries often, as well as setting changes in mid-window and single-cycle windows. The bench's own model tracks window deadlines as absolute cycle numbers rather than with a down-counter, so the cycle of every strobe and every count is checked.

// File: rtl/freq_gate_pkg.sv
package freq_gate_pkg;

  localparam int ARITH_W = 32;

  typedef enum logic {
    GATE_IDLE = 1'b0,
    GATE_RUN  = 1'b1
  } gate_state_e;

  // Value loaded into the gate down-counter: a window of n ticks counts n-1..0.
  // A setting of zero is treated as a window of one tick.
  function automatic logic [ARITH_W-1:0] reload_of(input logic [ARITH_W-1:0] ticks);
    return (ticks == '0) ? '0 : ticks - 1'b1;
  endfunction

  // Tally after one cycle: restart on a boundary, otherwise accumulate.
  function automatic logic [ARITH_W-1:0] tally_next(input logic [ARITH_W-1:0] tally,
                                                   input logic              ev,
                                                   input logic              boundary);
    logic [ARITH_W-1:0] inc;
    inc = {{(ARITH_W-1){1'b0}}, ev};
    return boundary ? inc : tally + inc;
  endfunction

endpackage

// File: rtl/sig_sync.sv
module sig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= sig_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

  // Two rising edges cannot occur on back-to-back cycles.
  AST_EDGE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R2

endmodule

// File: rtl/gate_timer.sv
module gate_timer #(
  parameter int TICK_W = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TICK_W-1:0] ticks_i,
  output logic              start_o,
  output logic              expire_o,
  output logic              boundary_o
);
  import freq_gate_pkg::*;

  gate_state_e       state_q;
  logic [TICK_W-1:0] remain_q;
  logic [TICK_W-1:0] reload_val;

  assign reload_val = TICK_W'(reload_of(ARITH_W'(ticks_i)));
  assign start_o    = (state_q == GATE_IDLE);
  assign expire_o   = (state_q == GATE_RUN) && (remain_q == '0);
  assign boundary_o = start_o | expire_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= GATE_IDLE;
      remain_q <= '0;
    end else if (boundary_o) begin
      state_q  <= GATE_RUN;
      remain_q <= reload_val;
    end else begin
      remain_q <= remain_q - 1'b1;
    end
  end

  // Inside a window the gate steps down by exactly one per cycle.
  AST_GATE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!boundary_o) |=> (remain_q == $past(remain_q) - 1'b1)); // R3

  // Once running, the gate never returns to idle without reset.
  AST_GATE_STAYS_RUN: assert property (@(posedge clk) disable iff (rst)
    (state_q == GATE_RUN) |=> (state_q == GATE_RUN)); // R8

endmodule

// File: rtl/edge_tally.sv
module edge_tally #(
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  input  logic             boundary_i,
  input  logic             expire_i,
  output logic [CNT_W-1:0] tally_o,
  output logic [CNT_W-1:0] count_o,
  output logic             valid_o
);
  import freq_gate_pkg::*;

  logic [CNT_W-1:0] tally_q;
  logic [CNT_W-1:0] result_q;
  logic             valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tally_q  <= '0;
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      tally_q <= CNT_W'(tally_next(ARITH_W'(tally_q), rise_i, boundary_i));
      valid_q <= expire_i;
      if (expire_i) result_q <= tally_q;
    end
  end

  assign tally_o = tally_q;
  assign count_o = result_q;
  assign valid_o = valid_q;

  // The tally must never wrap inside a window.
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !((&tally_q) && rise_i && !boundary_i)); // R4

  // The result only moves together with the strobe.
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!valid_q) |-> $stable(result_q)); // R9

endmodule

// File: rtl/freq_gate_counter.sv
module freq_gate_counter #(
  parameter int TICK_W      = 27,
  parameter int CNT_W       = TICK_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sig_i,
  input  logic [TICK_W-1:0] gate_ticks_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              count_valid_o
);
  logic             rise_ev;
  logic             win_start;
  logic             win_expire;
  logic             win_boundary;
  logic [CNT_W-1:0] tally_now;

  sig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (sig_i),
    .rise_o (rise_ev)
  );

  gate_timer #(.TICK_W(TICK_W)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .ticks_i    (gate_ticks_i),
    .start_o    (win_start),
    .expire_o   (win_expire),
    .boundary_o (win_boundary)
  );

  edge_tally #(.CNT_W(CNT_W)) u_tally (
    .clk        (clk),
    .rst        (rst),
    .rise_i     (rise_ev),
    .boundary_i (win_boundary),
    .expire_i   (win_expire),
    .tally_o    (tally_now),
    .count_o    (count_o),
    .valid_o    (count_valid_o)
  );

  // An edge on a closing cycle opens the next window with a tally of one.
  AST_RESTART_ONE: assert property (@(posedge clk) disable iff (rst)
    (win_boundary && rise_ev) |=> (tally_now == CNT_W'(1))); // R5

  // The window opened by reset release never produces a strobe.
  AST_NO_STROBE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !count_valid_o); // R8

  // The first cycle after reset is always the load cycle.
  AST_START_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> win_start); // R8

endmodule

// File: tb/freq_gate_counter_bench.sv
module freq_gate_counter_bench;
  localparam int TICK_W = 27;
  localparam int CNT_W  = 27;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sig = 1'b0;
  logic [TICK_W-1:0] ticks = TICK_W'(20);
  logic [CNT_W-1:0]  count;
  logic              valid;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;
  string tag   = "R8";

  always #4 clk = ~clk;

  freq_gate_counter #(.TICK_W(TICK_W), .CNT_W(CNT_W), .SYNC_STAGES(2)) u_freq_gate_counter (
    .clk           (clk),
    .rst           (rst),
    .sig_i         (sig),
    .gate_ticks_i  (ticks),
    .count_o       (count),
    .count_valid_o (valid)
  );

  // Reference model: deadlines held as absolute cycle numbers.
  bit      b1, b2, b3;
  bit      m_run;
  longint  m_next;
  longint  m_tally;
  longint  exp_count;
  bit      exp_valid;

  function automatic longint eff_ticks(input logic [TICK_W-1:0] t);
    return (t == 0) ? 1 : longint'(t);
  endfunction

  always @(posedge clk) begin
    bit ev;
    cyc = cyc + 1;
    if (rst) begin
      b1 = 0; b2 = 0; b3 = 0;
      m_run = 0; m_tally = 0; exp_count = 0; exp_valid = 0;
    end else begin
      ev = b2 && !b3;
      if (!m_run) begin
        m_run = 1;
        m_tally = ev;
        m_next = cyc + eff_ticks(ticks);
        exp_valid = 0;
      end else if (cyc == m_next) begin
        exp_count = m_tally;
        exp_valid = 1;
        m_tally = ev;
        m_next = cyc + eff_ticks(ticks);
      end else begin
        m_tally = m_tally + ev;
        exp_valid = 0;
      end
      b3 = b2; b2 = b1; b1 = sig;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (valid !== exp_valid)
        check(0, "R3 strobe timing", valid, exp_valid);
      else if (exp_valid)
        check(count == CNT_W'(exp_count), tag, count, exp_count);
      else if (cyc % 50 == 0)
        check(count == CNT_W'(exp_count), "R9 hold", count, exp_count);
    end
  end

  task automatic wave(input int hi, input int lo, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      sig = ((i % (hi + lo)) < hi);
    end
  endtask

  task automatic noise(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      sig = $urandom_range(0, 1);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R8: reset state
    check(count == 0, "R8 reset count", count, 0);
    check(valid == 0, "R8 reset strobe", valid, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check(valid == 0 && count == 0, "R8 first window no strobe", count, 0);

    tag = "R4 square period 6";
    wave(3, 3, 200);
    tag = "R1 single pulse";
    ticks = TICK_W'(16);
    wave(1, 40, 200);
    tag = "R2 held high";
    sig = 1'b1;
    repeat (80) @(negedge clk);
    tag = "R2 held low";
    sig = 1'b0;
    repeat (60) @(negedge clk);
    tag = "R5 edges on boundaries";
    ticks = TICK_W'(6);
    wave(1, 2, 200);
    tag = "R4 random input";
    ticks = TICK_W'(37);
    noise(400);
    tag = "R6 mid-window change";
    for (int k = 0; k < 20; k++) begin
      ticks = TICK_W'($urandom_range(2, 30));
      noise($urandom_range(3, 25));
    end
    tag = "R10 one-tick gate";
    ticks = TICK_W'(1);
    wave(1, 1, 60);
    noise(60);
    tag = "R7 zero gate";
    ticks = TICK_W'(0);
    noise(60);
    tag = "R3 two-tick gate";
    ticks = TICK_W'(2);
    wave(2, 3, 80);
    tag = "R4 random gates";
    for (int k = 0; k < 15; k++) begin
      ticks = TICK_W'($urandom_range(1, 45));
      wave($urandom_range(1, 4), $urandom_range(1, 4), $urandom_range(40, 120));
    end
    // R8: reset again mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(count == 0 && valid == 0, "R8 reset mid-run", count, 0);
    rst = 1'b0;
    tag = "R4 after reset";
    ticks = TICK_W'(25);
    wave(2, 2, 150);
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule